// File: doc/BRIEF.md
# Hybrid Nearest-Level Arm Modulator

This block turns one sampled arm voltage reference per control step into two commands for a converter arm. The arm holds a string of slow half-bridge cells and one fast module. The block tells the slow cells how many of them to insert, and it gives the fast module a fractional residual reference that its own PWM stage then realises. The reference arrives as an unsigned fixed-point number in units of the nominal cell voltage. Its integer part is the nearest-level step count and its fractional bits are the part left over.

The fast module can shape either a positive or a negative pulse train. In the positive mode (mode I) the slow cells round down and the module adds the fraction. In the negative mode (mode II) one more cell is inserted and the module subtracts the complement. The two modes move charge into or out of the fast module's capacitors in opposite directions. The block therefore picks a mode from the arm current direction and from the summed capacitor voltage of the fast module. It makes this choice only at the moment the step count moves to a new value, so the choice changes at the fundamental rate and not at every sample.

Top module: `hybrid_arm_modulator`

## Requirements
- R1: After reset, `out_vld` is 0, `cell_cnt` is 0, `mode_neg` is 0 (mode I) and `resid` is 0.
- R2: A sample taken with `ref_vld` high gives `out_vld` high for exactly one cycle, on the clock edge that samples it. The other outputs keep their values until the next accepted sample.
- R3: In mode I (`mode_neg` = 0), `cell_cnt` equals the step count and `resid` equals the fractional bits of the reference, which is zero or positive. The step count is the integer part of `ref_q`, that is the bits above the low FRAC_W bits.
- R4: In mode II (`mode_neg` = 1), `cell_cnt` equals the step count plus one. `resid` equals the fraction minus 2^FRAC_W, which is always negative. `resid` is two's complement in units of 2^-FRAC_W of a cell voltage.
- R5: If the step count of an accepted sample equals the step count of the previous accepted sample, the mode is kept unchanged. After reset the previous step count is 0.
- R6: When the step count changes to a value of N_CELLS−1 or more, mode I is chosen whatever the current direction or the voltages.
- R7: When the step count changes to a value below N_CELLS−1 with `cur_pos` = 1 (positive arm current), mode I is chosen if `hf_vsum` < `cell_vnom`. Otherwise mode II is chosen.
- R8: When the step count changes to a value below N_CELLS−1 with `cur_pos` = 0 (negative arm current), mode II is chosen if `hf_vsum` < `cell_vnom`. Otherwise mode I is chosen.
- R9: `hf_vsum` equal to `cell_vnom` is treated as above the nominal value in both current directions.
- R10: A reference whose integer part exceeds N_CELLS is treated as exactly N_CELLS with a zero fraction. `cell_cnt` never exceeds N_CELLS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_vld | input | 1 | Sample strobe for the reference and the measurements |
| ref_q | input | INT_W+FRAC_W | Arm reference, unsigned, cell voltage = 2^FRAC_W |
| cur_pos | input | 1 | Arm current direction, 1 = positive |
| hf_vsum | input | VOLT_W | Summed capacitor voltage of the fast module |
| cell_vnom | input | VOLT_W | Nominal cell voltage, same scale as hf_vsum |
| out_vld | output | 1 | One-cycle strobe marking fresh outputs |
| cell_cnt | output | INT_W | Number of slow cells to insert |
| mode_neg | output | 1 | Fast-module polarity, 0 = mode I, 1 = mode II |
| resid | output | FRAC_W+1 | Signed residual reference for the fast module |

## Verification
Every result appears one clock edge after the sample is accepted. `cell_cnt`, `mode_neg`, `resid` and `out_vld` all update on the same edge that sees `ref_vld` high. The bench raises `ref_vld` on a falling edge and reads all four outputs on the next falling edge. It reads again one falling edge later to confirm that the strobe has dropped and that the values are held. Expected values come from a small model in the bench. The model keeps its own previous step count and mode, so that the hold rule, the forced mode I and the tie rule can each be checked against sequences of samples chosen to reach them.

// File: rtl/hnl_pkg.sv
package hnl_pkg;
  typedef enum logic {
    MODE_POS = 1'b0,
    MODE_NEG = 1'b1
  } hf_mode_e;
endpackage

// File: rtl/hnl_ref_split.sv
// Splits the fixed-point arm reference into a step count and a fraction,
// saturating anything above the full arm at exactly N_CELLS cells.
module hnl_ref_split #(
  parameter int N_CELLS = 8,
  parameter int INT_W   = 4,
  parameter int FRAC_W  = 8
) (
  input  logic [INT_W+FRAC_W-1:0] ref_q,
  output logic [INT_W-1:0]        lvl,
  output logic [FRAC_W-1:0]       frac
);
  localparam logic [INT_W-1:0] LVL_MAX = INT_W'(N_CELLS);

  logic [INT_W-1:0]  raw_int;
  logic [FRAC_W-1:0] raw_frac;

  always_comb begin
    raw_int  = ref_q[INT_W+FRAC_W-1:FRAC_W];
    raw_frac = ref_q[FRAC_W-1:0];
    if (raw_int >= LVL_MAX) begin
      lvl  = LVL_MAX;
      frac = '0;
    end else begin
      lvl  = raw_int;
      frac = raw_frac;
    end
  end
endmodule

// File: rtl/hnl_mode_select.sv
// Decides the fast-module polarity, only when the step count moves.
module hnl_mode_select
  import hnl_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int INT_W   = 4,
  parameter int VOLT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [INT_W-1:0]  lvl,
  input  logic              cur_pos,
  input  logic [VOLT_W-1:0] hf_vsum,
  input  logic [VOLT_W-1:0] cell_vnom,
  output hf_mode_e          mode_nxt,
  output hf_mode_e          mode_q
);
  localparam logic [INT_W-1:0] LVL_TOP = INT_W'(N_CELLS - 1);

  logic [INT_W-1:0] lvl_prev;
  logic             lvl_moved;
  logic             vsum_low;

  always_comb begin
    lvl_moved = (lvl != lvl_prev);
    vsum_low  = (hf_vsum < cell_vnom);
    mode_nxt  = mode_q;
    if (lvl_moved) begin
      if (lvl >= LVL_TOP)
        mode_nxt = MODE_POS;
      else if (cur_pos)
        mode_nxt = vsum_low ? MODE_POS : MODE_NEG;
      else
        mode_nxt = vsum_low ? MODE_NEG : MODE_POS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= '0;
      mode_q   <= MODE_POS;
    end else if (smp_vld) begin
      lvl_prev <= lvl;
      mode_q   <= mode_nxt;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && lvl == lvl_prev) |=> (mode_q == $past(mode_q))); // R5

  AST_TOP_FORCE: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && lvl >= LVL_TOP) |=> (mode_q == MODE_POS)); // R6
endmodule

// File: rtl/hnl_out_stage.sv
// Registers the cell count, polarity and signed residual once per sample.
module hnl_out_stage
  import hnl_pkg::*;
#(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [INT_W-1:0]  lvl,
  input  logic [FRAC_W-1:0] frac,
  input  hf_mode_e          mode_nxt,
  output logic              out_vld,
  output logic [INT_W-1:0]  cell_cnt,
  output logic              mode_neg,
  output logic [FRAC_W:0]   resid
);
  logic [INT_W-1:0] cnt_d;
  logic [FRAC_W:0]  resid_d;

  always_comb begin
    if (mode_nxt == MODE_NEG) begin
      cnt_d   = lvl + INT_W'(1);
      resid_d = {1'b1, frac};
    end else begin
      cnt_d   = lvl;
      resid_d = {1'b0, frac};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      cell_cnt <= '0;
      mode_neg <= 1'b0;
      resid    <= '0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) begin
        cell_cnt <= cnt_d;
        mode_neg <= (mode_nxt == MODE_NEG);
        resid    <= resid_d;
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(smp_vld)); // R2

  AST_RESID_POS: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !mode_neg) |-> !resid[FRAC_W]); // R3

  AST_RESID_NEG: assert property (@(posedge clk) disable iff (rst)
    (out_vld && mode_neg) |-> resid[FRAC_W]); // R4
endmodule

// File: rtl/hybrid_arm_modulator.sv
module hybrid_arm_modulator
  import hnl_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int FRAC_W  = 8,
  parameter int VOLT_W  = 12,
  localparam int INT_W  = $clog2(N_CELLS + 1),
  localparam int REF_W  = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_vld,
  input  logic [REF_W-1:0]  ref_q,
  input  logic              cur_pos,
  input  logic [VOLT_W-1:0] hf_vsum,
  input  logic [VOLT_W-1:0] cell_vnom,
  output logic              out_vld,
  output logic [INT_W-1:0]  cell_cnt,
  output logic              mode_neg,
  output logic [FRAC_W:0]   resid
);
  localparam logic [INT_W-1:0] CNT_MAX = INT_W'(N_CELLS);

  logic [INT_W-1:0]  lvl;
  logic [FRAC_W-1:0] frac;
  hf_mode_e          mode_nxt;
  hf_mode_e          mode_q;

  hnl_ref_split #(.N_CELLS(N_CELLS), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_split (
    .ref_q (ref_q),
    .lvl   (lvl),
    .frac  (frac)
  );

  hnl_mode_select #(.N_CELLS(N_CELLS), .INT_W(INT_W), .VOLT_W(VOLT_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (ref_vld),
    .lvl       (lvl),
    .cur_pos   (cur_pos),
    .hf_vsum   (hf_vsum),
    .cell_vnom (cell_vnom),
    .mode_nxt  (mode_nxt),
    .mode_q    (mode_q)
  );

  hnl_out_stage #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (ref_vld),
    .lvl      (lvl),
    .frac     (frac),
    .mode_nxt (mode_nxt),
    .out_vld  (out_vld),
    .cell_cnt (cell_cnt),
    .mode_neg (mode_neg),
    .resid    (resid)
  );

  AST_CNT_MAX: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (cell_cnt <= CNT_MAX)); // R10

  AST_MODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (mode_neg == (mode_q == MODE_NEG))); // R5
endmodule

// File: tb/hybrid_arm_modulator_test.sv
module hybrid_arm_modulator_test;
  localparam int N_CELLS = 8;
  localparam int FRAC_W  = 8;
  localparam int VOLT_W  = 12;
  localparam int INT_W   = $clog2(N_CELLS + 1);
  localparam int REF_W   = INT_W + FRAC_W;
  localparam int VNOM    = 750;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ref_vld = 1'b0;
  logic [REF_W-1:0]  ref_q = '0;
  logic              cur_pos = 1'b1;
  logic [VOLT_W-1:0] hf_vsum = '0;
  logic [VOLT_W-1:0] cell_vnom = VOLT_W'(VNOM);
  logic              out_vld;
  logic [INT_W-1:0]  cell_cnt;
  logic              mode_neg;
  logic [FRAC_W:0]   resid;

  int checks = 0;
  int errors = 0;
  int m_prev = 0;
  int m_mode = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hybrid_arm_modulator #(.N_CELLS(N_CELLS), .FRAC_W(FRAC_W), .VOLT_W(VOLT_W)) uut (
    .clk(clk), .rst(rst), .ref_vld(ref_vld), .ref_q(ref_q), .cur_pos(cur_pos),
    .hf_vsum(hf_vsum), .cell_vnom(cell_vnom), .out_vld(out_vld),
    .cell_cnt(cell_cnt), .mode_neg(mode_neg), .resid(resid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one sample, predict it, check the strobe cycle and the hold cycle.
  task automatic sample(input string req, input int ip, input int fp,
                        input bit pos, input int vs);
    int fl, fr, cnt, rs;
    fl = (ip >= N_CELLS) ? N_CELLS : ip;
    fr = (ip >= N_CELLS) ? 0 : fp;
    if (fl != m_prev) begin
      if (fl >= N_CELLS - 1) m_mode = 0;
      else if (pos)          m_mode = (vs < VNOM) ? 0 : 1;
      else                   m_mode = (vs < VNOM) ? 1 : 0;
    end
    m_prev = fl;
    cnt = fl + m_mode;
    rs  = m_mode ? fr - (1 << FRAC_W) : fr;
    @(negedge clk);
    ref_q   = REF_W'((ip << FRAC_W) | fp);
    cur_pos = pos;
    hf_vsum = VOLT_W'(vs);
    ref_vld = 1'b1;
    @(negedge clk);
    ref_vld = 1'b0;
    ref_q   = '0;
    check({req, " out_vld"}, int'(out_vld), 1);
    check({req, " cell_cnt"}, int'(cell_cnt), cnt);
    check({req, " mode"}, int'(mode_neg), m_mode);
    check({req, " resid"}, int'($signed(resid)), rs);
    @(negedge clk);
    check("R2 strobe drop", int'(out_vld), 0);
    check("R2 count held", int'(cell_cnt), cnt);
    check("R2 resid held", int'($signed(resid)), rs);
  endtask

  task automatic test_reset();
    check("R1 out_vld", int'(out_vld), 0);
    check("R1 cell_cnt", int'(cell_cnt), 0);
    check("R1 mode", int'(mode_neg), 0);
    check("R1 resid", int'($signed(resid)), 0);
  endtask

  task automatic test_mode_one();
    sample("R3 R7 split pos low", 3, 8'h40, 1'b1, 700);
  endtask

  task automatic test_mode_two();
    sample("R4 R7 split pos high", 5, 8'h80, 1'b1, 800);
    sample("R4 zero fraction", 2, 8'h00, 1'b1, 760);
  endtask

  task automatic test_hold();
    sample("R4 setup", 5, 8'h20, 1'b1, 800);
    sample("R5 hold despite low vsum", 5, 8'h10, 1'b1, 700);
    sample("R5 hold despite neg current", 5, 8'hF0, 1'b0, 900);
  endtask

  task automatic test_negative();
    sample("R8 neg low", 2, 8'h33, 1'b0, 700);
    sample("R8 neg high", 4, 8'h99, 1'b0, 800);
  endtask

  task automatic test_tie();
    sample("R9 tie pos", 6, 8'h11, 1'b1, VNOM);
    sample("R9 tie neg", 1, 8'h22, 1'b0, VNOM);
  endtask

  task automatic test_force();
    sample("R6 top pos high", 7, 8'h7F, 1'b1, 800);
    sample("R6 low then", 3, 8'h01, 1'b0, 700);
    sample("R6 top neg low", 7, 8'h05, 1'b0, 700);
    sample("R6 full arm", 8, 8'h00, 1'b0, 700);
  endtask

  task automatic test_clamp();
    sample("R10 setup", 4, 8'h00, 1'b1, 800);
    sample("R10 over range", 12, 8'h55, 1'b1, 800);
    sample("R10 max code", 15, 8'hFF, 1'b0, 700);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_mode_one();
    test_mode_two();
    test_hold();
    test_negative();
    test_tie();
    test_force();
    test_clamp();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule